// File: doc/BRIEF.md
# Byte-Wide Configuration Loader

This block is the host side of a parallel configuration download into a programmable target device. On a start request it pulses the target's active-low program line and waits for the target's ready line to fall and then rise again. It then streams bytes from an upstream valid/ready source onto an 8-bit bus, qualified by active-low select and write-direction lines. It also produces the configuration clock from the system clock by an even division ratio. The target samples the bus on the rising configuration-clock edge, so the loader changes the bus only while that clock is low.

When the target raises its busy line at a sampling edge, the byte was not taken. The loader then presents the same byte at the next edge, and keeps doing so until busy is seen low. After the byte marked last is taken, the loader releases the bus select and keeps clocking the target so that it can finish its start-up sequence. This goes on until the target reports done, or until a bounded number of extra edges has been issued. If the ready line falls at any point after the first ready indication, the run stops with an error. The outcome is held on three verdict flags until the next start.

Top module: `cfg_loader_top`

## Requirements
- R1: After reset the loader is idle: `cfg_prog_n`, `cfg_cs_n` and `cfg_wr_n` are 1, `cfg_clk` is 0, `s_ready` is 0 and all four status outputs are 0.
- R2: A `start` pulse while idle drives `cfg_prog_n` low for exactly PROG_PULSE system cycles and raises `st_busy`. A `start` pulse while busy produces no second program pulse.
- R3: After the program pulse the loader waits for `cfg_ready` to go low and then high. It issues no configuration-clock edge before that. If INIT_WAIT_MAX cycles pass in this wait, the run ends with `st_timeout` = 1.
- R4: During the byte phase `cfg_cs_n` and `cfg_wr_n` are both 0. `cfg_d` changes and `s_ready` is 1 only while `cfg_clk` is 0.
- R5: The bytes seen on `cfg_d` at rising `cfg_clk` edges with `cfg_busy` = 0 equal the accepted upstream bytes, in order, with none lost or duplicated.
- R6: If `cfg_busy` = 1 at a rising edge, the next rising edge carries the same byte.
- R7: While `s_valid` is 0 and no byte is held, no rising edge is issued. The number of rising edges in the byte phase equals the number of bytes plus the number of busy stalls.
- R8: After the byte with `s_last` = 1 is taken, `cfg_cs_n` returns to 1 and clocking continues. If `cfg_done` rises after K extra edges, exactly K extra edges are issued and the run ends with `st_done_ok` = 1.
- R9: If `cfg_done` stays 0, exactly STARTUP_MAX extra edges are issued and the run ends with `st_timeout` = 1.
- R10: If `cfg_ready` falls during the byte phase or the start-up phase, the run ends with `st_error` = 1. No further rising edge is issued and `cfg_cs_n` returns to 1.
- R11: At most one verdict flag is set. The flags hold while idle and are cleared, with `st_busy` set, in the cycle after an accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a download when idle |
| s_valid | input | 1 | Upstream byte valid |
| s_data | input | DW | Upstream byte |
| s_last | input | 1 | Marks the final byte of the stream |
| s_ready | output | 1 | Loader accepts the upstream byte |
| cfg_prog_n | output | 1 | Active-low program strobe to the target |
| cfg_cs_n | output | 1 | Active-low select to the target |
| cfg_wr_n | output | 1 | Active-low write direction to the target |
| cfg_clk | output | 1 | Configuration clock |
| cfg_d | output | DW | Configuration data bus |
| cfg_ready | input | 1 | Target ready line (low = resetting or error) |
| cfg_busy | input | 1 | Target busy; byte not taken at this edge |
| cfg_done | input | 1 | Target configuration complete |
| st_busy | output | 1 | Download in progress |
| st_done_ok | output | 1 | Last run ended with done |
| st_error | output | 1 | Last run ended with a ready-line drop |
| st_timeout | output | 1 | Last run ended by an init-wait or start-up limit |

## Verification
The bench acts as the target and checks every captured byte against a computed sequence. The stream is tried four ways: back to back, with upstream gaps, with a busy stall every third edge, and with both together. Gaps show that edges are withheld rather than issued with stale data. Stalls show that a refused byte is repeated rather than skipped. Counting edges after the last byte separates a done-terminated start-up from one stopped at the edge limit. Runs with a dropped ready line mid-stream and with a ready line that never falls cover the error and init-wait exits.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  typedef enum logic [2:0] {
    LD_IDLE,
    LD_PROG,
    LD_WAIT_LO,
    LD_WAIT_HI,
    LD_XFER,
    LD_START
  } ld_state_e;

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // configuration clock level for a given phase count
  function automatic logic clk_level(int unsigned ph, int unsigned half);
    return ph >= half;
  endfunction

  // busy decision: live value in the sampling cycle, held value later
  function automatic logic busy_refused(logic chk_en, logic at_sample,
                                        logic busy_now, logic busy_held);
    return chk_en && (at_sample ? busy_now : busy_held);
  endfunction

endpackage

// File: rtl/cfg_phase_gen.sv
module cfg_phase_gen
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CLK_DIV = 4,
  parameter int unsigned PH_W    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic hold,
  output logic cfg_clk,
  output logic rise_evt,
  output logic smp_evt,
  output logic end_evt
);
  localparam int unsigned HALF = CLK_DIV / 2;
  localparam logic [PH_W-1:0] PH_PRE  = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (!run) begin
      ph_q <= '0;
    end else if (ph_q == PH_PRE && hold) begin
      ph_q <= ph_q;
    end else if (ph_q == PH_LAST) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign cfg_clk  = clk_level(32'(ph_q), HALF);
  assign rise_evt = run && (ph_q == PH_PRE) && !hold;
  assign smp_evt  = run && (ph_q == PH_HALF);
  assign end_evt  = run && (ph_q == PH_LAST);

endmodule

// File: rtl/cfg_byte_hold.sv
module cfg_byte_hold
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter bit          BUSY_CHECK = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load_en,
  input  logic [DW-1:0] din,
  input  logic          din_last,
  input  logic          smp_evt,
  input  logic          end_evt,
  input  logic          cfg_busy,
  output logic          have_byte,
  output logic [DW-1:0] dout,
  output logic          dout_last,
  output logic          stall_evt,
  output logic          take_evt
);
  logic busy_held;
  logic refused;
  logic have_q;

  generate
    if (BUSY_CHECK) begin : g_busy
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       busy_q <= 1'b0;
        else if (smp_evt) busy_q <= cfg_busy;
      end
      assign busy_held = busy_q;
    end else begin : g_nobusy
      assign busy_held = 1'b0;
    end
  endgenerate

  assign refused   = busy_refused(BUSY_CHECK, smp_evt, cfg_busy, busy_held);
  assign take_evt  = end_evt && have_q && !refused;
  assign stall_evt = end_evt && have_q && refused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
    end else if (clr) begin
      have_q <= 1'b0;
    end else if (load_en) begin
      have_q <= 1'b1;
    end else if (take_evt) begin
      have_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout      <= '0;
      dout_last <= 1'b0;
    end else if (load_en) begin
      dout      <= din;
      dout_last <= din_last;
    end
  end

  assign have_byte = have_q;

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
  import cfg_loader_pkg::*;
#(
  parameter int unsigned PROG_PULSE    = 3,
  parameter int unsigned INIT_WAIT_MAX = 4096,
  parameter int unsigned STARTUP_MAX   = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cfg_ready,
  input  logic cfg_done,
  input  logic have_byte,
  input  logic take_evt,
  input  logic last_held,
  input  logic rise_evt,
  output logic run,
  output logic hold,
  output logic clr,
  output logic xfer,
  output logic prog_n,
  output logic st_busy,
  output logic st_done_ok,
  output logic st_error,
  output logic st_timeout
);
  localparam int unsigned CNT_MAX = max3(PROG_PULSE, INIT_WAIT_MAX, STARTUP_MAX);
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PROG_END = CNT_W'(PROG_PULSE - 1);
  localparam logic [CNT_W-1:0] WAIT_END = CNT_W'(INIT_WAIT_MAX - 1);
  localparam logic [CNT_W-1:0] SU_END   = CNT_W'(STARTUP_MAX);

  ld_state_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ok_q, ok_d, err_q, err_d, to_q, to_d;
  logic             active, abort;

  assign active = (st_q == LD_XFER) || (st_q == LD_START);
  assign abort  = active && (!cfg_ready || cfg_done ||
                             ((st_q == LD_START) && (cnt_q == SU_END)));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ok_d  = ok_q;
    err_d = err_q;
    to_d  = to_q;
    unique case (st_q)
      LD_IDLE: begin
        if (start) begin
          st_d  = LD_PROG;
          cnt_d = '0;
          ok_d  = 1'b0;
          err_d = 1'b0;
          to_d  = 1'b0;
        end
      end
      LD_PROG: begin
        if (cnt_q == PROG_END) begin
          st_d  = LD_WAIT_LO;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      LD_WAIT_LO, LD_WAIT_HI: begin
        cnt_d = cnt_q + 1'b1;
        if (st_q == LD_WAIT_LO && !cfg_ready) begin
          st_d = LD_WAIT_HI;
        end else if (st_q == LD_WAIT_HI && cfg_ready) begin
          st_d  = LD_XFER;
          cnt_d = '0;
        end else if (cnt_q == WAIT_END) begin
          st_d = LD_IDLE;
          to_d = 1'b1;
        end
      end
      LD_XFER: begin
        if (!cfg_ready) begin
          st_d  = LD_IDLE;
          err_d = 1'b1;
        end else if (cfg_done) begin
          st_d = LD_IDLE;
          ok_d = 1'b1;
        end else if (take_evt && last_held) begin
          st_d  = LD_START;
          cnt_d = '0;
        end
      end
      LD_START: begin
        if (!cfg_ready) begin
          st_d  = LD_IDLE;
          err_d = 1'b1;
        end else if (cfg_done) begin
          st_d = LD_IDLE;
          ok_d = 1'b1;
        end else if (cnt_q == SU_END) begin
          st_d = LD_IDLE;
          to_d = 1'b1;
        end else if (rise_evt) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LD_IDLE;
      cnt_q <= '0;
      ok_q  <= 1'b0;
      err_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
      err_q <= err_d;
      to_q  <= to_d;
    end
  end

  assign run        = active;
  assign xfer       = (st_q == LD_XFER);
  assign hold       = (xfer && !have_byte) || abort;
  assign clr        = (st_q == LD_IDLE);
  assign prog_n     = (st_q != LD_PROG);
  assign st_busy    = (st_q != LD_IDLE);
  assign st_done_ok = ok_q;
  assign st_error   = err_q;
  assign st_timeout = to_q;

endmodule

// File: rtl/cfg_loader_top.sv
module cfg_loader_top
  import cfg_loader_pkg::*;
#(
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_DIV       = 4,
  parameter int unsigned PROG_PULSE    = 3,
  parameter int unsigned INIT_WAIT_MAX = 4096,
  parameter int unsigned STARTUP_MAX   = 1024,
  parameter bit          BUSY_CHECK    = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          s_valid,
  input  logic [DW-1:0] s_data,
  input  logic          s_last,
  output logic          s_ready,
  output logic          cfg_prog_n,
  output logic          cfg_cs_n,
  output logic          cfg_wr_n,
  output logic          cfg_clk,
  output logic [DW-1:0] cfg_d,
  input  logic          cfg_ready,
  input  logic          cfg_busy,
  input  logic          cfg_done,
  output logic          st_busy,
  output logic          st_done_ok,
  output logic          st_error,
  output logic          st_timeout
);
  localparam int unsigned PH_W = $clog2(CLK_DIV);

  logic run, hold, clr, xfer;
  logic rise_evt, smp_evt, end_evt;
  logic have_byte, last_held, stall_evt, take_evt, load_en;

  cfg_phase_gen #(.CLK_DIV(CLK_DIV), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .hold(hold),
    .cfg_clk(cfg_clk), .rise_evt(rise_evt), .smp_evt(smp_evt), .end_evt(end_evt)
  );

  assign s_ready = xfer && !have_byte && !cfg_clk;
  assign load_en = s_ready && s_valid;

  cfg_byte_hold #(.DW(DW), .BUSY_CHECK(BUSY_CHECK)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_en(load_en),
    .din(s_data), .din_last(s_last), .smp_evt(smp_evt), .end_evt(end_evt),
    .cfg_busy(cfg_busy), .have_byte(have_byte), .dout(cfg_d),
    .dout_last(last_held), .stall_evt(stall_evt), .take_evt(take_evt)
  );

  cfg_seq #(.PROG_PULSE(PROG_PULSE), .INIT_WAIT_MAX(INIT_WAIT_MAX),
            .STARTUP_MAX(STARTUP_MAX)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_ready(cfg_ready),
    .cfg_done(cfg_done), .have_byte(have_byte), .take_evt(take_evt),
    .last_held(last_held), .rise_evt(rise_evt), .run(run), .hold(hold),
    .clr(clr), .xfer(xfer), .prog_n(cfg_prog_n), .st_busy(st_busy),
    .st_done_ok(st_done_ok), .st_error(st_error), .st_timeout(st_timeout)
  );

  assign cfg_cs_n = !xfer;
  assign cfg_wr_n = !xfer;

endmodule

// File: rtl/cfg_loader_checker.sv
module cfg_loader_checker #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          s_ready,
  input logic          cfg_prog_n,
  input logic          cfg_cs_n,
  input logic          cfg_clk,
  input logic [DW-1:0] cfg_d,
  input logic          st_busy,
  input logic          st_done_ok,
  input logic          st_error,
  input logic          st_timeout,
  input logic          stall_evt
);
  AST_START_PROG: assert property (@(posedge clk) disable iff (!rst_n)
    start && !st_busy |=> st_busy && !cfg_prog_n); // R2
  AST_PROG_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> !cfg_clk && cfg_cs_n); // R3
  AST_READY_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cfg_clk); // R4
  AST_DATA_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clk && $past(cfg_clk) |-> $stable(cfg_d)); // R4
  AST_STALL_KEEPS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_evt |=> $stable(cfg_d)); // R6
  AST_HALT_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
    st_error && $past(st_error) |-> !cfg_clk && cfg_cs_n); // R10
  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_done_ok, st_error, st_timeout})); // R11
  AST_VERDICT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !st_busy && $past(!st_busy) && !$past(start)
      |-> $stable({st_done_ok, st_error, st_timeout})); // R11
endmodule

bind cfg_loader_top cfg_loader_checker #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .s_ready(s_ready),
  .cfg_prog_n(cfg_prog_n), .cfg_cs_n(cfg_cs_n), .cfg_clk(cfg_clk),
  .cfg_d(cfg_d), .st_busy(st_busy), .st_done_ok(st_done_ok),
  .st_error(st_error), .st_timeout(st_timeout), .stall_evt(stall_evt)
);

// File: tb/cfg_loader_top_bench.sv
module cfg_loader_top_bench;
  localparam int DW = 8;
  localparam int PULSE = 3;
  localparam int WAITMAX = 40;
  localparam int SUMAX = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic s_last = 1'b0;
  logic s_ready, cfg_prog_n, cfg_cs_n, cfg_wr_n, cfg_clk;
  logic [DW-1:0] cfg_d;
  logic tgt_ready = 1'b0;
  logic busy_drv = 1'b0;
  logic done_drv = 1'b0;
  logic st_busy, st_done_ok, st_error, st_timeout;

  always #10 clk = ~clk;

  cfg_loader_top #(.DW(DW), .CLK_DIV(4), .PROG_PULSE(PULSE),
                   .INIT_WAIT_MAX(WAITMAX), .STARTUP_MAX(SUMAX),
                   .BUSY_CHECK(1'b1)) u_cfg_loader_top (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid),
    .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .cfg_prog_n(cfg_prog_n), .cfg_cs_n(cfg_cs_n), .cfg_wr_n(cfg_wr_n),
    .cfg_clk(cfg_clk), .cfg_d(cfg_d), .cfg_ready(tgt_ready),
    .cfg_busy(busy_drv), .cfg_done(done_drv), .st_busy(st_busy),
    .st_done_ok(st_done_ok), .st_error(st_error), .st_timeout(st_timeout)
  );

  // run configuration, written by the sequence process only
  int c_n = 0, c_seed = 0, c_err_at = 0, c_done_after = 0;
  bit c_busy_mode = 0, c_gap_mode = 0, c_stuck = 0;

  // reference model state, written by the monitor process only
  int snd_idx, got, xfer_edges, stalls, su_edges, early_edges;
  int prog_cnt, prog_w, prog_pulses, post, cyc;
  bit armed, prev_hs, prev_prog, clk_prev, stall_pend;
  logic [DW-1:0] stall_byte, d_rise;
  int m_checks = 0, m_fail = 0;
  int q_checks = 0, q_fail = 0;

  function automatic logic [DW-1:0] pat(int seed, int k);
    return DW'((k * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic qchk(bit ok, string tag, int act, int exp);
    q_checks++;
    if (!ok) begin
      q_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // cycle-by-cycle target model, sender and comparison, away from the edge
  always @(negedge clk) begin
    if (!rst_n) begin
      snd_idx = 0; got = 0; xfer_edges = 0; stalls = 0; su_edges = 0;
      early_edges = 0; prog_cnt = 0; prog_w = 0; prog_pulses = 0; post = 0;
      cyc = 0; armed = 0; prev_hs = 0; prev_prog = 1; clk_prev = 0;
      stall_pend = 0; stall_byte = '0; d_rise = '0;
    end else begin
      if (start && !st_busy) begin
        snd_idx = 0; got = 0; xfer_edges = 0; stalls = 0; su_edges = 0;
        early_edges = 0; prog_pulses = 0; prog_cnt = 0; prev_hs = 0;
        stall_pend = 0; done_drv = 1'b0; armed = 0;
        if (c_stuck) tgt_ready = 1'b1;
      end
      if (prev_hs) snd_idx++;
      // target reaction to the program strobe
      if (!cfg_prog_n) begin
        prog_cnt++;
        done_drv = 1'b0;
        if (!c_stuck) begin tgt_ready = 1'b0; armed = 1; post = 0; end
      end else begin
        if (!prev_prog) begin prog_w = prog_cnt; prog_cnt = 0; prog_pulses++; end
        if (armed && !tgt_ready) begin
          post++;
          if (post == 6) begin tgt_ready = 1'b1; armed = 0; end
        end
      end
      prev_prog = cfg_prog_n;
      // rising configuration-clock edge
      if (cfg_clk && !clk_prev) begin
        if (!tgt_ready) early_edges++;
        if (!cfg_cs_n) begin
          xfer_edges++;
          m_checks++;
          if (cfg_wr_n) begin
            m_fail++;
            $display("FAIL R4: wr_n actual %0d expected 0", cfg_wr_n);
          end
          if (busy_drv) begin
            stalls++; stall_pend = 1; stall_byte = cfg_d;
          end else begin
            if (stall_pend) begin
              m_checks++;
              if (cfg_d !== stall_byte) begin
                m_fail++;
                $display("FAIL R6: byte after stall actual %0h expected %0h", cfg_d, stall_byte);
              end
            end
            m_checks++;
            if (cfg_d !== pat(c_seed, got)) begin
              m_fail++;
              $display("FAIL R5: byte %0d actual %0h expected %0h", got, cfg_d, pat(c_seed, got));
            end
            got++; stall_pend = 0;
          end
          d_rise = cfg_d;
        end else begin
          su_edges++;
          if (c_done_after > 0 && su_edges == c_done_after) done_drv = 1'b1;
        end
      end else if (cfg_clk && !cfg_cs_n) begin
        m_checks++;
        if (cfg_d !== d_rise) begin
          m_fail++;
          $display("FAIL R4: data moved in high phase actual %0h expected %0h", cfg_d, d_rise);
        end
      end
      clk_prev = cfg_clk;
      if (s_ready && cfg_clk) begin
        m_checks++; m_fail++;
        $display("FAIL R4: s_ready in high phase actual 1 expected 0");
      end
      // injected ready drop
      if (c_err_at > 0 && got == c_err_at && tgt_ready && !armed) tgt_ready = 1'b0;
      // busy for the coming edge, chosen while the clock is low
      if (!cfg_clk) busy_drv = c_busy_mode && !cfg_cs_n && (xfer_edges % 3 == 1);
      // upstream sender
      s_valid = (snd_idx < c_n) && !(c_gap_mode && (cyc % 5 < 2));
      s_data  = pat(c_seed, snd_idx);
      s_last  = (snd_idx == c_n - 1);
      prev_hs = s_valid && s_ready;
      cyc++;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic run_begin(int n, int seed, bit bm, bit gm, int dafter, int errat, bit stuck);
    c_n = n; c_seed = seed; c_busy_mode = bm; c_gap_mode = gm;
    c_done_after = dafter; c_err_at = errat; c_stuck = stuck;
    tick();
    start = 1'b1;
    tick();
    start = 1'b0;
    qchk(st_busy && !st_done_ok && !st_error && !st_timeout, "R11 cleared on start",
         {st_busy, st_done_ok, st_error, st_timeout}, 4'b1000);
    qchk(!cfg_prog_n, "R2 program strobe low", cfg_prog_n, 0);
  endtask

  task automatic run_wait();
    while (st_busy) tick();
    tick();
  endtask

  initial begin
    repeat (3) tick();
    qchk(cfg_prog_n && cfg_cs_n && cfg_wr_n && !cfg_clk && !s_ready &&
         !st_busy && !st_done_ok && !st_error && !st_timeout, "R1 reset state",
         {cfg_prog_n, cfg_cs_n, cfg_wr_n, cfg_clk, s_ready, st_busy,
          st_done_ok, st_error, st_timeout}, 9'b111000000);
    rst_n = 1'b1;
    tick();

    // back-to-back stream, done after 3 start-up edges
    run_begin(12, 1, 0, 0, 3, 0, 0);
    run_wait();
    qchk(prog_w == PULSE, "R2 program pulse width", prog_w, PULSE);
    qchk(early_edges == 0, "R3 no edge before ready", early_edges, 0);
    qchk(got == 12, "R5 bytes captured", got, 12);
    qchk(xfer_edges == 12, "R7 edges without gaps", xfer_edges, 12);
    qchk(su_edges == 3, "R8 start-up edges until done", su_edges, 3);
    qchk(st_done_ok && !st_error && !st_timeout, "R8 verdict ok", st_done_ok, 1);

    // busy stalls and upstream gaps, with a start while busy
    run_begin(20, 7, 1, 1, 5, 0, 0);
    repeat (30) tick();
    start = 1'b1;
    tick();
    start = 1'b0;
    run_wait();
    qchk(prog_pulses == 1, "R2 start while busy ignored", prog_pulses, 1);
    qchk(got == 20, "R5 bytes with stalls and gaps", got, 20);
    qchk(stalls > 0, "R6 stalls occurred", stalls, 1);
    qchk(xfer_edges == got + stalls, "R7 edges equal bytes plus stalls", xfer_edges, got + stalls);
    qchk(su_edges == 5, "R8 start-up edges", su_edges, 5);
    qchk(st_done_ok, "R8 verdict ok after stalls", st_done_ok, 1);
    repeat (10) tick();
    qchk(st_done_ok && !st_busy, "R11 verdict held while idle", st_done_ok, 1);

    // gaps only
    run_begin(9, 3, 0, 1, 2, 0, 0);
    run_wait();
    qchk(got == 9 && xfer_edges == 9, "R7 gaps add no edges", xfer_edges, 9);

    // done never arrives
    run_begin(6, 5, 1, 0, 0, 0, 0);
    run_wait();
    qchk(su_edges == SUMAX, "R9 start-up edge limit", su_edges, SUMAX);
    qchk(st_timeout && !st_done_ok && !st_error, "R9 timeout verdict", st_timeout, 1);

    // ready drops after 5 bytes
    run_begin(12, 9, 0, 0, 3, 5, 0);
    run_wait();
    qchk(st_error && !st_done_ok && !st_timeout, "R10 error verdict", st_error, 1);
    qchk(got == 5, "R10 no byte after ready drop", got, 5);
    qchk(early_edges == 0 && su_edges == 0, "R10 clock halted", early_edges + su_edges, 0);
    qchk(cfg_cs_n && !cfg_clk, "R10 bus released", {cfg_cs_n, cfg_clk}, 2'b10);

    // ready never falls
    run_begin(4, 2, 0, 0, 1, 0, 1);
    run_wait();
    qchk(st_timeout && !st_error && !st_done_ok, "R3 init wait timeout", st_timeout, 1);
    qchk(xfer_edges == 0 && got == 0, "R3 nothing sent", xfer_edges, 0);

    $display("End of test - %0d assertions evaluated, %0d failures",
             q_checks + m_checks, q_fail + m_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures",
             q_checks + m_checks + 1, q_fail + m_fail + 1);
    $finish;
  end

endmodule